// File: doc/BRIEF.md
# Dual-channel converter serial readout port

This block is the digital side of the serial port of a two-channel, simultaneous-sampling 12-bit converter. A host lowers an active-low select line and then toggles a serial clock. The block counts the falling clock edges of the frame. It keeps both data pins released while the conversion runs, then shifts each channel's two's-complement result out of its own pin, most significant bit first. The results come in on two parallel ports from a stand-in for the analog core, and the block captures them just before shifting begins.

If the host keeps the select line low after the first result, each pin goes on to carry the other channel's result. One serial line can then collect both conversions.

The data input pin has two uses. When all four gain-select inputs are low, it feeds a 12-bit control register that is written during the frame. The register changes only when the frame delivered a full word before the select line rose.

All inputs are taken as synchronous to the system clock `clk`. Edges of the serial clock and of the select line are detected by comparing each input with its value one `clk` earlier.

Top module: `dual_adc_serial_port`

## Requirements
- R1: After reset, both output enables are low and `ctrl_q` is zero.
- R2: A high-to-low change of `cs_n` starts a frame with the edge count at zero. Whenever `cs_n` is high, the frame ends, both enables drop in the following cycle and any partial state is discarded.
- R3: During falling serial-clock edges 1 to 18 of a frame, both output enables stay low.
- R4: Both results are captured from `res_a`/`res_b` at falling edge 18. Later changes on those ports do not change the bits shifted in that frame.
- R5: Falling edge 19 raises both enables and drives bit 11 of the pin's own channel (pin A carries `res_a`, pin B carries `res_b`). Edges 20 to 30 drive bits 10 down to 0, one per edge.
- R6: On edges 31 to 42, pin A carries bits 11..0 of `res_b` and pin B carries bits 11..0 of `res_a`. From edge 43 on, both enables stay low until the frame ends.
- R7: With `gain` equal to 4'b0000 on a falling edge, `sdi` is sampled as the next control bit. The first 12 such bits form the word MSB first. `ctrl_q` takes that word when `cs_n` rises, provided all 12 were received.
- R8: Falling edges where `gain` is nonzero do not sample `sdi`, and `ctrl_q` keeps its value.
- R9: A frame that ends with fewer than 12 control bits leaves `ctrl_q` unchanged.
- R10: Data outputs change only in the cycle after a falling serial-clock edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; the block acts on its falling edges |
| sdi | input | 1 | Control-register serial input |
| gain | input | 4 | Gain-select inputs; all low enables register writes |
| res_a | input | 12 | Channel A result, two's complement |
| res_b | input | 12 | Channel B result, two's complement |
| dout_a | output | 1 | Serial data, pin A |
| oe_a | output | 1 | Drive enable for pin A |
| dout_b | output | 1 | Serial data, pin B |
| oe_b | output | 1 | Drive enable for pin B |
| ctrl_q | output | 12 | Control register contents |

## Verification
The bench aims at the frame boundaries: edges 18, 19, 30, 31, 42 and 43. A design that is off by one edge there would release its pins a bit early, drop the LSB, or let the chained word run one bit too long. It changes the result ports right after the capture edge; a design that sampled them late would shift out the new value. Frames are also aborted during the conversion phase and during readout, so a counter that survives a raised select line would misalign the next frame. Control writes are sent with the gain pins nonzero and with too few bits, and either case would corrupt `ctrl_q` in a design that samples too freely.

// File: rtl/dual_adc_serial_port.sv
module dual_adc_serial_port #(
  parameter int DW         = 12,
  parameter int LATCH_EDGE = 18,
  parameter int CTRL_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [3:0]        gain,
  input  logic [DW-1:0]     res_a,
  input  logic [DW-1:0]     res_b,
  output logic              dout_a,
  output logic              oe_a,
  output logic              dout_b,
  output logic              oe_b,
  output logic [CTRL_W-1:0] ctrl_q
);

  localparam int MSB_I   = LATCH_EDGE + 1;
  localparam int LAST_I  = LATCH_EDGE + 2 * DW;
  localparam int CW      = $clog2(LAST_I + 2);
  localparam int NW      = $clog2(CTRL_W + 1);
  localparam logic [CW-1:0] E_LATCH = CW'(LATCH_EDGE);
  localparam logic [CW-1:0] E_MSB   = CW'(MSB_I);
  localparam logic [CW-1:0] E_LAST  = CW'(LAST_I);
  localparam logic [CW-1:0] E_SAT   = CW'(LAST_I + 1);
  localparam logic [NW-1:0] N_FULL  = NW'(CTRL_W);

  logic              sclk_q, cs_q, act;
  logic [CW-1:0]     cnt;
  logic [NW-1:0]     ctl_n;
  logic [CTRL_W-1:0] ctl_sh;
  logic [2*DW-1:0]   sh_a, sh_b;

  wire           fall = sclk_q & ~sclk;
  wire [CW-1:0]  nxt  = cnt + CW'(1);
  wire           en   = act && (cnt >= E_MSB) && (cnt <= E_LAST);

  assign oe_a   = en;
  assign oe_b   = en;
  assign dout_a = sh_a[2*DW-1];
  assign dout_b = sh_b[2*DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
      act    <= 1'b0;
      cnt    <= '0;
      ctl_n  <= '0;
      ctl_sh <= '0;
      ctrl_q <= '0;
      sh_a   <= '0;
      sh_b   <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) begin
        act   <= 1'b0;
        cnt   <= '0;
        ctl_n <= '0;
        if (!cs_q && ctl_n == N_FULL) ctrl_q <= ctl_sh;
      end else if (cs_q) begin
        act   <= 1'b1;
        cnt   <= '0;
        ctl_n <= '0;
      end else if (act && fall) begin
        if (cnt != E_SAT) cnt <= nxt;
        if (nxt == E_LATCH) begin
          sh_a <= {res_a, res_b};
          sh_b <= {res_b, res_a};
        end else if (nxt > E_MSB && nxt <= E_LAST) begin
          sh_a <= {sh_a[2*DW-2:0], 1'b0};
          sh_b <= {sh_b[2*DW-2:0], 1'b0};
        end
        if (gain == 4'b0000 && ctl_n != N_FULL) begin
          ctl_sh <= {ctl_sh[CTRL_W-2:0], sdi};
          ctl_n  <= ctl_n + NW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/dual_adc_serial_port_chk.sv
module dual_adc_serial_port_chk #(
  parameter int CW = 6,
  parameter int NW = 4,
  parameter int CTRL_W = 12,
  parameter int MSB_I = 19,
  parameter int LAST_I = 42
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic [3:0]        gain,
  input logic              oe_a,
  input logic              oe_b,
  input logic              dout_a,
  input logic              dout_b,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CW-1:0]     cnt,
  input logic [NW-1:0]     ctl_n
);

  a_r2_cs_high_releases: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!oe_a && !oe_b));

  a_r3_enable_starts_at_msb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_a) |-> (cnt == CW'(MSB_I)));

  a_r6_released_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(LAST_I + 1)) |-> (!oe_a && !oe_b));

  a_r7_ctrl_moves_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$past(cs_n) && cs_n) |=> $stable(ctrl_q));

  a_r8_gain_blocks_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && gain != 4'b0000) |=> (ctl_n == $past(ctl_n)));

  a_r10_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(sclk) && !sclk) |=> ($stable(dout_a) && $stable(dout_b)));

endmodule

bind dual_adc_serial_port dual_adc_serial_port_chk #(
  .CW(CW), .NW(NW), .CTRL_W(CTRL_W), .MSB_I(MSB_I), .LAST_I(LAST_I)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .gain(gain),
  .oe_a(oe_a), .oe_b(oe_b), .dout_a(dout_a), .dout_b(dout_b),
  .ctrl_q(ctrl_q), .cnt(cnt), .ctl_n(ctl_n)
);

// File: tb/dual_adc_serial_port_bench.sv
`timescale 1ns/1ps
module dual_adc_serial_port_bench;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [3:0]  gain = 4'h0;
  logic [11:0] res_a = '0, res_b = '0;
  logic dout_a, oe_a, dout_b, oe_b;
  logic [11:0] ctrl_q;

  int vectors = 0, fails = 0, cycles = 0;
  bit running = 0;
  string ctl_tag = "R7";

  always #2.5 clk = ~clk;

  dual_adc_serial_port u_dual_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .gain(gain),
    .res_a(res_a), .res_b(res_b), .dout_a(dout_a), .oe_a(oe_a),
    .dout_b(dout_b), .oe_b(oe_b), .ctrl_q(ctrl_q));

  // behavioural reference
  bit m_act = 0, m_oe = 0, m_da = 0, m_db = 0, p_sclk = 1, p_cs = 1;
  int m_edges = 0;
  bit qa[$], qb[$], qc[$];
  logic [11:0] m_ctrl = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_oe = 0; m_edges = 0; qa.delete(); qb.delete(); qc.delete();
      m_ctrl = '0; p_sclk = 1; p_cs = 1;
    end else begin
      if (cs_n) begin
        if (!p_cs && qc.size() == 12) begin
          for (int i = 0; i < 12; i++) m_ctrl[11-i] = qc[i];
        end
        m_act = 0; m_oe = 0; m_edges = 0; qc.delete();
      end else if (p_cs) begin
        m_act = 1; m_edges = 0; qc.delete();
      end else if (m_act && p_sclk && !sclk) begin
        m_edges++;
        if (m_edges == 18) begin
          qa.delete(); qb.delete();
          for (int i = 11; i >= 0; i--) begin qa.push_back(res_a[i]); qb.push_back(res_b[i]); end
          for (int i = 11; i >= 0; i--) begin qa.push_back(res_b[i]); qb.push_back(res_a[i]); end
        end
        if (m_edges >= 19 && m_edges <= 42) begin
          m_oe = 1; m_da = qa.pop_front(); m_db = qb.pop_front();
        end else m_oe = 0;
        if (gain == 4'h0 && qc.size() < 12) qc.push_back(sdi);
      end
      p_sclk = sclk; p_cs = cs_n;
    end
  end

  function automatic string edge_tag();
    if (!m_act || m_edges > 42) return "R2";
    if (m_edges < 19) return "R3";
    if (m_edges <= 30) return "R5";
    return "R6";
  endfunction

  always @(negedge clk) begin
    if (running) begin
      vectors++;
      if (oe_a !== m_oe || oe_b !== m_oe) begin
        fails++;
        $display("FAIL %s enables at edge %0d: got %b/%b expected %b", edge_tag(), m_edges, oe_a, oe_b, m_oe);
      end
      if (m_oe && (dout_a !== m_da || dout_b !== m_db)) begin
        fails++;
        $display("FAIL %s/R4 data at edge %0d: got %b/%b expected %b/%b", edge_tag(), m_edges, dout_a, dout_b, m_da, m_db);
      end
      if (ctrl_q !== m_ctrl) begin
        fails++;
        $display("FAIL %s ctrl_q: got %h expected %h", ctl_tag, ctrl_q, m_ctrl);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 200000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(int n, logic [11:0] a, logic [11:0] b, logic [11:0] wr,
                       logic [3:0] g, int change_at, string tag);
    ctl_tag = tag;
    gain = g; res_a = a; res_b = b;
    wait_n(2);
    cs_n = 1'b0;
    wait_n(2);
    for (int e = 1; e <= n; e++) begin
      sdi = (e <= 12) ? wr[12-e] : 1'b0;
      if (e == change_at) begin res_a = ~res_a; res_b = ~res_b; end
      sclk = 1'b0; wait_n(2);
      sclk = 1'b1; wait_n(2);
    end
    cs_n = 1'b1;
    wait_n(4);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    vectors++;
    if (oe_a !== 1'b0 || oe_b !== 1'b0 || ctrl_q !== 12'h000) begin
      fails++;
      $display("FAIL R1 reset state: got %b/%b %h expected 0/0 000", oe_a, oe_b, ctrl_q);
    end
    running = 1;
    frame(31, 12'h5A3, 12'hC71, 12'hA5C, 4'h0, 0,  "R7");   // R5 normal readout, R7 write
    frame(45, 12'h800, 12'h7FF, 12'h0F0, 4'h3, 0,  "R8");   // R6 chain, R8 gain nonzero
    frame(10, 12'h123, 12'h456, 12'hFFF, 4'h0, 0,  "R9");   // R2 abort in conversion, R9 short write
    frame(25, 12'hF0F, 12'h0F0, 12'h000, 4'h1, 0,  "R8");   // R2 abort during readout
    frame(31, 12'h800, 12'h7FF, 12'h000, 4'h2, 19, "R8");   // R4 inputs change after capture
    frame(31, 12'h001, 12'hFFE, 12'h000, 4'h2, 10, "R8");   // R4 change before capture
    frame(43, 12'h9C3, 12'h36A, 12'h3C1, 4'h0, 0,  "R7");   // R6 full chain, R7 second write
    frame(20, 12'hAAA, 12'h555, 12'hFFF, 4'h0, 0,  "R7");   // R7 12 bits then early end
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule